// File: doc/BRIEF.md
# Indirect configuration register bank with keyed soft reset

This block gives a host a small set of configuration registers for a serial bus controller while using only two byte locations. Location 0 holds an index pointer and location 1 is a data window onto whichever internal register the pointer selects. The internal registers are an own-address byte, a timeout byte, a mode field and two clock period bytes (low phase and high phase). Their values are driven out continuously to the neighbouring bus logic.

One pointer value selects no storage. It selects a reset-key target instead. Writing the first key byte and then the second key byte through the window at that target makes the block issue a one-cycle soft reset pulse. That pulse returns every internal register and the pointer to its default. A wrong byte or a pointer write between the two key bytes cancels the sequence. Software can detect that the bank exists by writing the own-address register and reading the same value back.

Top module: `ind_cfg_bank`

## Requirements
- R1: While rst_ni is low and after it rises, the pointer reads 0x00 and the outputs hold their defaults: own address 0x00, timeout 0xFF, mode 0, clock low period 0x9D, clock high period 0x86, soft_rst_o low.
- R2: A write with host_addr_i = 0 stores the full byte in the pointer. A read with host_addr_i = 0 returns the pointer.
- R3: A write with host_addr_i = 1 updates the register that the pointer selects. Index 0x00 is own address, 0x01 timeout, 0x02 mode, 0x03 clock low period and 0x04 clock high period. The new value appears on the matching output after that clock edge, and a read with host_addr_i = 1 returns it.
- R4: Every byte value written to the own-address register reads back unchanged.
- R5: A write to the timeout register leaves the own-address register unchanged.
- R6: The mode register keeps only the low MODE_W bits of a written byte. Reads return those bits zero-extended to a byte.
- R7: A read with the pointer on an index with no storage returns 0x00. This includes the reset-key target 0x06. A window write to an index other than 0x00 through 0x04 and 0x06 changes no register.
- R8: With the pointer at 0x06, a window write of 0xA5 followed by a window write of 0x5A resets the bank. At the clock edge of the second write, every register and the pointer take their defaults. soft_rst_o is then high for exactly the one following cycle.
- R9: The key sequence is cancelled by any window byte other than 0x5A written after 0xA5, and that byte does not itself count as a first key byte. It is also cancelled by any pointer write. Key bytes written while the pointer is not 0x06 have no effect.
- R10: A low level on rst_ni resets all state at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe, one byte per cycle |
| host_addr_i | input | 1 | 0 selects the pointer, 1 selects the data window |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Read byte of the addressed location (combinational) |
| own_addr_o | output | 8 | Own-address register |
| timeout_o | output | 8 | Timeout register |
| mode_o | output | MODE_W | Mode register |
| scl_low_o | output | 8 | Clock low period register |
| scl_high_o | output | 8 | Clock high period register |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |

## Verification
The bench builds the block with its default parameters. With MODE_W = 2, the masking of mode writes and the zero-extended readback can be observed. Because the pointer is a full byte, the bench sweeps all 256 pointer values with a window write and a readback at each one. That sweep reaches every defined index and every undefined index, including the reset-key target. A second sweep writes all 256 byte values to the own-address register. Directed key sequences cover the correct order, a wrong second byte, a repeated first byte, a pointer write between the bytes and key bytes at the wrong target.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int unsigned DW   = 8;
  localparam int unsigned NREG = 5;

  typedef enum logic [DW-1:0] {
    IDX_OWN  = 8'h00,
    IDX_TMO  = 8'h01,
    IDX_MODE = 8'h02,
    IDX_SCLL = 8'h03,
    IDX_SCLH = 8'h04,
    IDX_KEY  = 8'h06
  } idx_e;

  typedef enum logic {KEY_IDLE = 1'b0, KEY_ARMED = 1'b1} key_st_e;
endpackage

// File: rtl/ind_cfg_decode.sv
module ind_cfg_decode
  import cfg_bank_pkg::*;
#(
  parameter logic [DW-1:0] KEY_IDX = IDX_KEY
) (
  input  logic [DW-1:0]   ptr_i,
  output logic [NREG-1:0] sel_o,
  output logic            key_sel_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel_o[i] = (ptr_i == DW'(i));
  end
  assign key_sel_o = (ptr_i == KEY_IDX);
endmodule

// File: rtl/ind_cfg_regs.sv
module ind_cfg_regs
  import cfg_bank_pkg::*;
#(
  parameter logic [NREG*DW-1:0] RST_VAL = '0,
  parameter logic [NREG*DW-1:0] MASK    = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [NREG-1:0]   sel_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [NREG*DW-1:0] q_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] RV = RST_VAL[i*DW +: DW];
    localparam logic [DW-1:0] MK = MASK[i*DW +: DW];
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              q <= RV & MK;
      else if (clr_i)           q <= RV & MK;
      else if (we_i && sel_i[i]) q <= wdata_i & MK;
    end
    assign q_o[i*DW +: DW] = q;
  end
endmodule

// File: rtl/ind_cfg_key.sv
module ind_cfg_key
  import cfg_bank_pkg::*;
#(
  parameter logic [DW-1:0] KEY_FIRST  = 8'hA5,
  parameter logic [DW-1:0] KEY_SECOND = 8'h5A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ptr_we_i,
  input  logic          key_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          fire_o
);
  key_st_e st_q, st_d;

  assign fire_o = key_we_i && (st_q == KEY_ARMED) && (wdata_i == KEY_SECOND);

  always_comb begin
    st_d = st_q;
    if (ptr_we_i) st_d = KEY_IDLE;
    else if (key_we_i) begin
      if (st_q == KEY_ARMED)          st_d = KEY_IDLE;
      else if (wdata_i == KEY_FIRST)  st_d = KEY_ARMED;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KEY_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/ind_cfg_bank.sv
module ind_cfg_bank
  import cfg_bank_pkg::*;
#(
  parameter int unsigned     MODE_W     = 2,
  parameter logic [DW-1:0]   OWN_RST    = 8'h00,
  parameter logic [DW-1:0]   TMO_RST    = 8'hFF,
  parameter logic [DW-1:0]   MODE_RST   = 8'h00,
  parameter logic [DW-1:0]   SCLL_RST   = 8'h9D,
  parameter logic [DW-1:0]   SCLH_RST   = 8'h86,
  parameter logic [DW-1:0]   KEY_IDX    = IDX_KEY,
  parameter logic [DW-1:0]   KEY_FIRST  = 8'hA5,
  parameter logic [DW-1:0]   KEY_SECOND = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic              host_addr_i,
  input  logic [DW-1:0]     host_wdata_i,
  output logic [DW-1:0]     host_rdata_o,
  output logic [DW-1:0]     own_addr_o,
  output logic [DW-1:0]     timeout_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [DW-1:0]     scl_low_o,
  output logic [DW-1:0]     scl_high_o,
  output logic              soft_rst_o
);
  localparam logic [DW-1:0] MODE_MASK = DW'((1 << MODE_W) - 1);
  localparam logic [NREG*DW-1:0] RST_VAL = {SCLH_RST, SCLL_RST, MODE_RST, TMO_RST, OWN_RST};
  localparam logic [NREG*DW-1:0] MASK    = {8'hFF, 8'hFF, MODE_MASK, 8'hFF, 8'hFF};

  logic [DW-1:0]      ptr_q;
  logic [NREG-1:0]    sel;
  logic               key_sel;
  logic               ptr_we, win_we, fire, soft_rst_q;
  logic [NREG*DW-1:0] regs_q;

  assign ptr_we = host_we_i && !host_addr_i;
  assign win_we = host_we_i &&  host_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (fire)   ptr_q <= '0;
    else if (ptr_we) ptr_q <= host_wdata_i;
  end

  ind_cfg_decode #(.KEY_IDX(KEY_IDX)) u_dec (
    .ptr_i     (ptr_q),
    .sel_o     (sel),
    .key_sel_o (key_sel)
  );

  ind_cfg_regs #(.RST_VAL(RST_VAL), .MASK(MASK)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fire),
    .we_i    (win_we),
    .sel_i   (sel),
    .wdata_i (host_wdata_i),
    .q_o     (regs_q)
  );

  ind_cfg_key #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ptr_we_i (ptr_we),
    .key_we_i (win_we && key_sel),
    .wdata_i  (host_wdata_i),
    .fire_o   (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) soft_rst_q <= 1'b0;
    else         soft_rst_q <= fire;
  end

  always_comb begin
    host_rdata_o = '0;
    if (!host_addr_i) host_rdata_o = ptr_q;
    else begin
      for (int i = 0; i < NREG; i++)
        if (sel[i]) host_rdata_o = regs_q[i*DW +: DW];
    end
  end

  assign own_addr_o = regs_q[0*DW +: DW];
  assign timeout_o  = regs_q[1*DW +: DW];
  assign mode_o     = regs_q[2*DW +: MODE_W];
  assign scl_low_o  = regs_q[3*DW +: DW];
  assign scl_high_o = regs_q[4*DW +: DW];
  assign soft_rst_o = soft_rst_q;
endmodule

// File: rtl/ind_cfg_bank_chk.sv
module ind_cfg_bank_chk
  import cfg_bank_pkg::*;
#(
  parameter int unsigned   MODE_W     = 2,
  parameter logic [DW-1:0] OWN_RST    = 8'h00,
  parameter logic [DW-1:0] TMO_RST    = 8'hFF,
  parameter logic [DW-1:0] MODE_RST   = 8'h00,
  parameter logic [DW-1:0] SCLL_RST   = 8'h9D,
  parameter logic [DW-1:0] SCLH_RST   = 8'h86,
  parameter logic [DW-1:0] KEY_IDX    = IDX_KEY,
  parameter logic [DW-1:0] KEY_SECOND = 8'h5A
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_we_i,
  input logic              host_addr_i,
  input logic [DW-1:0]     host_wdata_i,
  input logic [DW-1:0]     ptr_i,
  input logic [DW-1:0]     own_addr_o,
  input logic [DW-1:0]     timeout_o,
  input logic [MODE_W-1:0] mode_o,
  input logic [DW-1:0]     scl_low_o,
  input logic [DW-1:0]     scl_high_o,
  input logic              soft_rst_o
);
  logic win_we;
  assign win_we = host_we_i && host_addr_i;

  assert_own_readback_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_we && ptr_i == IDX_OWN) |=> own_addr_o == $past(host_wdata_i));

  assert_timeout_isolated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_we && ptr_i == IDX_TMO) |=> $stable(own_addr_o));

  assert_mode_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_we && ptr_i == IDX_MODE) |=> mode_o == $past(host_wdata_i[MODE_W-1:0]));

  assert_undef_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_we && ptr_i >= DW'(NREG) && ptr_i != KEY_IDX)
      |=> $stable({own_addr_o, timeout_o, mode_o, scl_low_o, scl_high_o}));

  assert_pulse_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  assert_reset_defaults_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (ptr_i == '0 && own_addr_o == OWN_RST && timeout_o == TMO_RST &&
                    mode_o == MODE_RST[MODE_W-1:0] && scl_low_o == SCLL_RST &&
                    scl_high_o == SCLH_RST));

  assert_reset_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> $past(win_we && ptr_i == KEY_IDX && host_wdata_i == KEY_SECOND));
endmodule

bind ind_cfg_bank ind_cfg_bank_chk #(
  .MODE_W(MODE_W), .OWN_RST(OWN_RST), .TMO_RST(TMO_RST), .MODE_RST(MODE_RST),
  .SCLL_RST(SCLL_RST), .SCLH_RST(SCLH_RST), .KEY_IDX(KEY_IDX), .KEY_SECOND(KEY_SECOND)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_we_i(host_we_i), .host_addr_i(host_addr_i),
  .host_wdata_i(host_wdata_i), .ptr_i(ptr_q), .own_addr_o(own_addr_o),
  .timeout_o(timeout_o), .mode_o(mode_o), .scl_low_o(scl_low_o),
  .scl_high_o(scl_high_o), .soft_rst_o(soft_rst_o)
);

// File: tb/ind_cfg_bank_tb_top.sv
module ind_cfg_bank_tb_top;
  localparam int unsigned MW = 2;
  localparam logic [7:0] D_OWN = 8'h00, D_TMO = 8'hFF, D_MODE = 8'h00,
                         D_SCLL = 8'h9D, D_SCLH = 8'h86;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, own, tmo, scll, sclh;
  logic [MW-1:0] mode;
  logic srst;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m [5];
  logic [7:0] v;

  always #2 clk = ~clk;

  ind_cfg_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .own_addr_o(own),
    .timeout_o(tmo), .mode_o(mode), .scl_low_o(scll), .scl_high_o(sclh),
    .soft_rst_o(srst)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] msk(input int idx);
    return (idx == 2) ? 8'((1 << MW) - 1) : 8'hFF;
  endfunction

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " own"},  own, m[0]);
    chk({tag, " tmo"},  tmo, m[1]);
    chk({tag, " mode"}, 8'(mode), m[2]);
    chk({tag, " scll"}, scll, m[3]);
    chk({tag, " sclh"}, sclh, m[4]);
  endtask

  task automatic set_defaults();
    m[0] = D_OWN; m[1] = D_TMO; m[2] = D_MODE; m[3] = D_SCLL; m[4] = D_SCLH;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    set_defaults();
    #9; rst_n = 1'b1;
    // R1 reset state
    rd(1'b0, r); chk("R1 ptr", r, 8'h00);
    chk_outs("R1");
    chk("R1 srst", 8'(srst), 8'h00);
    rd(1'b1, r); chk("R1 window", r, D_OWN);

    // R4 all own-address bytes read back
    wr(1'b0, 8'h00);
    for (int d = 0; d < 256; d++) begin
      wr(1'b1, 8'(d));
      rd(1'b1, r); chk("R4 readback", r, 8'(d));
      chk("R4 port", own, 8'(d));
    end
    m[0] = 8'hFF;

    // R2 R3 R7 sweep of every pointer value
    for (int p = 0; p < 256; p++) begin
      wr(1'b0, 8'(p));
      rd(1'b0, r); chk("R2 ptr", r, 8'(p));
      v = 8'(p) ^ 8'h3C;
      wr(1'b1, v);
      if (p < 5) m[p] = v & msk(p);
      rd(1'b1, r); chk((p < 5) ? "R3 window" : "R7 window", r, (p < 5) ? m[p] : 8'h00);
      chk_outs((p < 5) ? "R3" : "R7");
    end

    // R5 timeout write isolation
    wr(1'b0, 8'h00); wr(1'b1, 8'h42); m[0] = 8'h42;
    wr(1'b0, 8'h01); wr(1'b1, 8'h17); m[1] = 8'h17;
    chk("R5 own", own, 8'h42);
    chk("R5 tmo", tmo, 8'h17);

    // R6 mode masking
    wr(1'b0, 8'h02); wr(1'b1, 8'hFF); m[2] = 8'((1 << MW) - 1);
    rd(1'b1, r); chk("R6 read", r, m[2]);
    chk("R6 port", 8'(mode), m[2]);
    wr(1'b1, 8'hFE); m[2] = 8'hFE & msk(2);
    rd(1'b1, r); chk("R6 read2", r, m[2]);

    // R9 sequences that must not reset
    wr(1'b0, 8'h06);
    wr(1'b1, 8'hA5); chk("R9 a", 8'(srst), 8'h00);
    wr(1'b1, 8'h00); wr(1'b1, 8'h5A); chk("R9 wrong byte", 8'(srst), 8'h00);
    wr(1'b1, 8'hA5); wr(1'b0, 8'h06); wr(1'b1, 8'h5A);
    chk("R9 ptr write", 8'(srst), 8'h00);
    wr(1'b1, 8'h5A); chk("R9 lone second", 8'(srst), 8'h00);
    wr(1'b1, 8'hA5); wr(1'b1, 8'hA5); wr(1'b1, 8'h5A);
    chk("R9 repeated first", 8'(srst), 8'h00);
    wr(1'b0, 8'h05); wr(1'b1, 8'hA5); wr(1'b1, 8'h5A);
    chk("R9 wrong target", 8'(srst), 8'h00);
    chk_outs("R9");

    // R8 correct key
    wr(1'b0, 8'h06); wr(1'b1, 8'hA5);
    chk("R8 armed", 8'(srst), 8'h00);
    wr(1'b1, 8'h5A);
    chk("R8 pulse", 8'(srst), 8'h01);
    set_defaults();
    chk_outs("R8");
    rd(1'b0, r); chk("R8 ptr", r, 8'h00);
    chk("R8 pulse end", 8'(srst), 8'h00);
    wr(1'b0, 8'h03); wr(1'b1, 8'h11); m[3] = 8'h11;
    wr(1'b0, 8'h06); wr(1'b1, 8'hA5); wr(1'b1, 8'h5A);
    chk("R8 second pulse", 8'(srst), 8'h01);
    set_defaults();
    chk_outs("R8 again");

    // R10 asynchronous reset
    wr(1'b0, 8'h00); wr(1'b1, 8'h55);
    chk("R10 pre", own, 8'h55);
    @(posedge clk); #1; rst_n = 1'b0; #0.5;
    chk("R10 async own", own, D_OWN);
    chk("R10 async ptr", rdata, (addr == 1'b0) ? 8'h00 : D_OWN);
    #5; rst_n = 1'b1;
    set_defaults();
    chk_outs("R10");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule